// File: doc/BRIEF.md
# Camera Link Base Transmitter Packer

This block turns a stream of parallel pixels into the serial form of a Camera Link base configuration. It takes one pixel and four flags per pixel period: frame valid, line valid, data valid and exposure enable. It places these into a 28-bit transmitter word using a fixed bit map, then splits the word into four 7-bit lane groups. It shifts each group out on its own data lane and drives a fifth lane with the pixel-rate clock pattern.

All logic runs on a single input clock, `ser_clk`, at seven times the pixel rate. One pixel period is seven `ser_clk` cycles. An internal phase counter marks the load edge. The first rising edge after reset is released is a load edge, and every seventh edge after it is one too. The pixel inputs only need to be valid at the load edge. A mode input selects between packing a 10-bit pixel and packing only its upper eight bits. The mode is taken only while frame valid is low, so that it stays fixed across a frame.

Top module: `cl_base_packer`

## Requirements
- R1: While `rst_n` is low, all four data lanes and the clock lane are 0. The first rising `ser_clk` edge after `rst_n` goes high is a load edge, and every seventh edge after it is also a load edge.
- R2: At each load edge the transmitter word Tx[27:0] is captured. Data lane k carries Tx[7k+6] down to Tx[7k], highest index first. Each bit is held for one `ser_clk` cycle, and the first bit appears right after the load edge.
- R3: Starting at each load edge, the clock lane outputs the 7-bit sequence 1,1,0,0,0,1,1.
- R4: In 10-bit mode (`mode_10b` = 1), pixel bit Dn for n = 0 to 7 goes to byte-A bit n. D8 goes to byte-B bit 0, and D9 goes to byte-B bit 1.
- R5: In 8-bit mode (`mode_10b` = 0), pixel bits D2 to D9 go to byte-A bits 0 to 7. D0 and D1 are dropped, and byte B carries no pixel bits.
- R6: Byte A maps onto Tx as follows: bits 0 to 4 go to Tx0 to Tx4, bit 5 to Tx6, bit 6 to Tx27, and bit 7 to Tx5.
- R7: Byte-B bit 0 maps to Tx7 and byte-B bit 1 maps to Tx8. All other byte-B and byte-C positions (Tx9 to Tx22) are always 0.
- R8: The flags sit at fixed Tx positions: line valid at Tx24, frame valid at Tx25, data valid at Tx26 and exposure enable at Tx23.
- R9: At a load edge with `fval` low, the word uses `mode_10b` and the block stores it. At a load edge with `fval` high, the word uses the stored mode and `mode_10b` is ignored. The stored mode resets to 10-bit.
- R10: Pixel and flag inputs that change between load edges have no effect on the bits being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | 10 | Pixel value, bit 0 is the LSB |
| fval | input | 1 | Frame valid flag |
| lval | input | 1 | Line valid flag |
| dval | input | 1 | Data valid flag |
| expen | input | 1 | Exposure enable flag |
| mode_10b | input | 1 | 1 = 10-bit packing, 0 = 8-bit packing |
| lane_dat | output | 4 | Serial data lanes, bit k is lane k |
| lane_clk | output | 1 | Serial clock lane pattern |

## Verification
Walking-one and all-ones pixels are sent in both modes. Because only one bit is set at a time, a pixel bit that lands at the wrong Tx position or in the wrong lane slot shows up alone. Each flag is set on its own, which separates the four flag positions from each other and from the pixel bits. A frame that toggles `mode_10b` while frame valid is high shows whether the mode is being held. Pixels whose inputs are changed partway through the pixel period show whether any logic samples outside the load edge. Long random runs, with frame valid rising and falling at random, mix all of these cases together.

// File: rtl/cl_pkg.sv
package cl_pkg;

   localparam int unsigned TX_BITS   = 28;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned TX_EXPEN  = 23;
   localparam int unsigned TX_LVAL   = 24;
   localparam int unsigned TX_FVAL   = 25;
   localparam int unsigned TX_DVAL   = 26;

   typedef struct packed {
      logic [BYTE_W-1:0] c;
      logic [BYTE_W-1:0] b;
      logic [BYTE_W-1:0] a;
   } cl_ports_t;

   typedef struct packed {
      logic fval;
      logic lval;
      logic dval;
      logic expen;
   } cl_flags_t;

   // Transmitter position of byte A bit i
   function automatic int unsigned pos_a(input int unsigned i);
      case (i)
         0, 1, 2, 3, 4: pos_a = i;
         5:             pos_a = 6;
         6:             pos_a = 27;
         default:       pos_a = 5;
      endcase
   endfunction

   // Transmitter position of byte B bit i
   function automatic int unsigned pos_b(input int unsigned i);
      case (i)
         0, 1, 2: pos_b = 7 + i;
         3, 4, 5: pos_b = 9 + i;
         6:       pos_b = 10;
         default: pos_b = 11;
      endcase
   endfunction

   // Transmitter position of byte C bit i
   function automatic int unsigned pos_c(input int unsigned i);
      case (i)
         0:             pos_c = 15;
         1, 2, 3, 4, 5: pos_c = 17 + i;
         6:             pos_c = 16;
         default:       pos_c = 17;
      endcase
   endfunction

endpackage

// File: rtl/cl_phase_gen.sv
module cl_phase_gen #(
   parameter int unsigned PHASES = 7,
   localparam int unsigned PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] phase,
   output logic            load
);

   localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

   generate
      if (PHASES < 2) begin : g_bad
         $error("cl_phase_gen: PHASES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (phase == LAST) begin
         phase <= '0;
      end else begin
         phase <= phase + 1'b1;
      end
   end

   assign load = (phase == '0);

endmodule

// File: rtl/cl_port_mapper.sv
module cl_port_mapper
   import cl_pkg::*;
#(
   parameter int unsigned PIX_W = 10,
   localparam int unsigned HI_W = PIX_W - BYTE_W
) (
   input  logic [PIX_W-1:0] pix,
   input  logic             wide,
   output cl_ports_t        ports
);

   generate
      if (PIX_W <= BYTE_W || PIX_W > 2 * BYTE_W) begin : g_bad
         $error("cl_port_mapper: PIX_W must lie between 9 and 16");
      end
   endgenerate

   logic [BYTE_W-1:0] a_wide;
   logic [BYTE_W-1:0] a_narrow;
   logic [BYTE_W-1:0] b_wide;

   // wide packing: low byte to A, remaining upper bits to B from bit 0
   assign a_wide = pix[BYTE_W-1:0];

   genvar gi;
   generate
      for (gi = 0; gi < BYTE_W; gi++) begin : g_b
         if (gi < HI_W) begin : g_used
            assign b_wide[gi] = pix[BYTE_W + gi];
         end else begin : g_zero
            assign b_wide[gi] = 1'b0;
         end
      end
   endgenerate

   // narrow packing: most significant byte to A
   assign a_narrow = pix[PIX_W-1 -: BYTE_W];

   always_comb begin
      ports   = '0;
      ports.a = wide ? a_wide : a_narrow;
      ports.b = wide ? b_wide : '0;
      ports.c = '0;
   end

endmodule

// File: rtl/cl_bit_router.sv
module cl_bit_router
   import cl_pkg::*;
(
   input  cl_ports_t            ports,
   input  cl_flags_t            flags,
   output logic [TX_BITS-1:0]   tx
);

   logic [TX_BITS-1:0] from_a;
   logic [TX_BITS-1:0] from_b;
   logic [TX_BITS-1:0] from_c;
   logic [TX_BITS-1:0] from_f;

   genvar gi;
   generate
      for (gi = 0; gi < BYTE_W; gi++) begin : g_bit
         assign from_a[pos_a(gi)] = ports.a[gi];
         assign from_b[pos_b(gi)] = ports.b[gi];
         assign from_c[pos_c(gi)] = ports.c[gi];
      end
   endgenerate

   // each byte covers only its own positions, the rest are zero
   generate
      for (gi = 0; gi < TX_BITS; gi++) begin : g_fill
         if (!((gi <= 6) || (gi == 27))) begin : g_a0
            assign from_a[gi] = 1'b0;
         end
         if (!(gi >= 7 && gi <= 14)) begin : g_b0
            assign from_b[gi] = 1'b0;
         end
         if (!(gi >= 15 && gi <= 22)) begin : g_c0
            assign from_c[gi] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      from_f           = '0;
      from_f[TX_EXPEN] = flags.expen;
      from_f[TX_LVAL]  = flags.lval;
      from_f[TX_FVAL]  = flags.fval;
      from_f[TX_DVAL]  = flags.dval;
   end

   assign tx = from_a | from_b | from_c | from_f;

endmodule

// File: rtl/cl_lane_serializer.sv
module cl_lane_serializer #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] par,
   output logic             ser
);

   generate
      if (WIDTH < 2) begin : g_bad
         $error("cl_lane_serializer: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (load) begin
         shreg <= par;
      end else begin
         shreg <= {shreg[WIDTH-2:0], 1'b0};
      end
   end

   assign ser = shreg[WIDTH-1];

endmodule

// File: rtl/cl_base_packer.sv
module cl_base_packer
   import cl_pkg::*;
#(
   parameter int unsigned PIX_W      = 10,
   parameter int unsigned LANES      = 4,
   parameter int unsigned LANE_BITS  = 7,
   parameter logic [6:0]  CLK_PAT    = 7'b1100011,
   localparam int unsigned PH_W      = $clog2(LANE_BITS)
) (
   input  logic             ser_clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix_data,
   input  logic             fval,
   input  logic             lval,
   input  logic             dval,
   input  logic             expen,
   input  logic             mode_10b,
   output logic [LANES-1:0] lane_dat,
   output logic             lane_clk
);

   generate
      if (LANES * LANE_BITS != TX_BITS) begin : g_bad_geom
         $error("cl_base_packer: LANES*LANE_BITS must equal 28");
      end
      if (LANE_BITS != 7) begin : g_bad_pat
         $error("cl_base_packer: clock pattern is 7 bits wide");
      end
   endgenerate

   logic [PH_W-1:0]    phase;
   logic               load;
   logic               mode_q;
   logic               mode_eff;
   cl_ports_t          ports;
   cl_flags_t          flags;
   logic [TX_BITS-1:0] tx;

   cl_phase_gen #(.PHASES(LANE_BITS)) u_phase (
      .clk   (ser_clk),
      .rst_n (rst_n),
      .phase (phase),
      .load  (load)
   );

   // packing mode only follows the input outside a frame
   assign mode_eff = fval ? mode_q : mode_10b;

   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b1;
      end else if (load && !fval) begin
         mode_q <= mode_10b;
      end
   end

   cl_port_mapper #(.PIX_W(PIX_W)) u_map (
      .pix   (pix_data),
      .wide  (mode_eff),
      .ports (ports)
   );

   always_comb begin
      flags.fval  = fval;
      flags.lval  = lval;
      flags.dval  = dval;
      flags.expen = expen;
   end

   cl_bit_router u_route (
      .ports (ports),
      .flags (flags),
      .tx    (tx)
   );

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         cl_lane_serializer #(.WIDTH(LANE_BITS)) u_ser (
            .clk   (ser_clk),
            .rst_n (rst_n),
            .load  (load),
            .par   (tx[gl*LANE_BITS +: LANE_BITS]),
            .ser   (lane_dat[gl])
         );
      end
   endgenerate

   cl_lane_serializer #(.WIDTH(LANE_BITS)) u_clk_ser (
      .clk   (ser_clk),
      .rst_n (rst_n),
      .load  (load),
      .par   (CLK_PAT[LANE_BITS-1:0]),
      .ser   (lane_clk)
   );

endmodule

// File: rtl/cl_base_packer_chk.sv
module cl_base_packer_chk #(
   parameter int unsigned LANES     = 4,
   parameter int unsigned PH_W      = 3,
   parameter int unsigned LANE_BITS = 7
) (
   input logic             ser_clk,
   input logic             rst_n,
   input logic             fval,
   input logic             lval,
   input logic             dval,
   input logic             expen,
   input logic             load,
   input logic             mode_q,
   input logic             mode_eff,
   input logic [PH_W-1:0]  phase,
   input logic [27:0]      tx,
   input logic [LANES-1:0] lane_dat,
   input logic             lane_clk
);

   // R1
   always @(negedge ser_clk) begin
      if (rst_n === 1'b0) begin
         rst_quiet_chk: assert (lane_dat == '0 && lane_clk == 1'b0);
      end
   end

   // R2
   phase_range_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      phase < PH_W'(LANE_BITS));

   // R3
   clk_low_run_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      $fell(lane_clk) |=> !lane_clk ##1 !lane_clk ##1 lane_clk);

   // R3
   clk_start_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      load |=> lane_clk);

   // R7
   unused_zero_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      tx[22:9] == '0);

   // R5
   narrow_b_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      !mode_eff |-> tx[8:7] == 2'b00);

   // R8
   flag_pos_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      tx[26:23] == {dval, fval, lval, expen});

   // R9
   mode_hold_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (load && fval) |=> $stable(mode_q));

endmodule

bind cl_base_packer cl_base_packer_chk #(
   .LANES     (LANES),
   .PH_W      (PH_W),
   .LANE_BITS (LANE_BITS)
) u_chk (
   .ser_clk  (ser_clk),
   .rst_n    (rst_n),
   .fval     (fval),
   .lval     (lval),
   .dval     (dval),
   .expen    (expen),
   .load     (load),
   .mode_q   (mode_q),
   .mode_eff (mode_eff),
   .phase    (phase),
   .tx       (tx),
   .lane_dat (lane_dat),
   .lane_clk (lane_clk)
);

// File: tb/cl_base_packer_tb.sv
module cl_base_packer_tb;

   logic       ser_clk = 1'b0;
   logic       rst_n;
   logic [9:0] pix_data;
   logic       fval, lval, dval, expen, mode_10b;
   logic [3:0] lane_dat;
   logic       lane_clk;

   int n_chk  = 0;
   int n_fail = 0;
   logic mdl_mode = 1'b1;
   logic finished = 1'b0;

   always #5 ser_clk = ~ser_clk;

   cl_base_packer u_dut (
      .ser_clk  (ser_clk),
      .rst_n    (rst_n),
      .pix_data (pix_data),
      .fval     (fval),
      .lval     (lval),
      .dval     (dval),
      .expen    (expen),
      .mode_10b (mode_10b),
      .lane_dat (lane_dat),
      .lane_clk (lane_clk)
   );

   // expected transmitter word, written from the requirements
   function automatic logic [27:0] exp_tx(input logic [9:0] p, input logic wide,
                                          input logic fv, input logic lv,
                                          input logic dv, input logic ee);
      logic [7:0] a;
      logic [1:0] b;
      logic [27:0] t;
      t = '0;
      if (wide) begin a = p[7:0]; b = p[9:8]; end   // R4
      else      begin a = p[9:2]; b = 2'b00;  end   // R5
      t[0] = a[0]; t[1] = a[1]; t[2] = a[2]; t[3] = a[3]; t[4] = a[4];  // R6
      t[6] = a[5]; t[27] = a[6]; t[5] = a[7];
      t[7] = b[0]; t[8] = b[1];                     // R7
      t[24] = lv; t[25] = fv; t[26] = dv; t[23] = ee; // R8
      return t;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [6:0] got, input logic [6:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
      end
   endtask

   // called at a negedge just before a load edge
   task automatic send(input string tag, input logic [9:0] p, input logic md,
                       input logic fv, input logic lv, input logic dv,
                       input logic ee, input logic disturb);
      logic [27:0] t;
      logic [6:0]  got [4];
      logic [6:0]  gclk;
      logic        wide;
      pix_data = p; mode_10b = md; fval = fv; lval = lv; dval = dv; expen = ee;
      if (!fv) mdl_mode = md;                       // R9
      wide = mdl_mode;
      t = exp_tx(p, wide, fv, lv, dv, ee);
      for (int j = 0; j < 7; j++) begin
         @(posedge ser_clk);
         @(negedge ser_clk);
         for (int k = 0; k < 4; k++) got[k][6-j] = lane_dat[k];
         gclk[6-j] = lane_clk;
         if (disturb && j == 2) begin                // R10
            pix_data = 10'($urandom); mode_10b = ~md; fval = ~fv;
            lval = ~lv; dval = ~dv; expen = ~ee;
         end
      end
      for (int k = 0; k < 4; k++)
         check(tag, $sformatf("R2 lane%0d", k), got[k], t[k*7 +: 7]);
      check(tag, "R3 clock lane", gclk, 7'b1100011);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; pix_data = '0; fval = 0; lval = 0; dval = 0; expen = 0; mode_10b = 1;
      repeat (4) @(negedge ser_clk);
      // R1 reset state
      check("R1", "reset lanes", {3'b0, lane_dat}, 7'd0);
      check("R1", "reset clock", {6'b0, lane_clk}, 7'd0);
      rst_n = 1'b1;
      // R1 first load right after release (checked by this word)
      send("R1", 10'h155, 1, 0, 0, 0, 0, 0);
      // R4 10-bit walking ones
      for (int i = 0; i < 10; i++) send("R4", 10'(1 << i), 1, 0, 1, 1, 0, 0);
      send("R4", 10'h3FF, 1, 0, 1, 1, 0, 0);
      // R5 8-bit walking ones, low bits dropped
      for (int i = 0; i < 10; i++) send("R5", 10'(1 << i), 0, 0, 1, 1, 0, 0);
      send("R5", 10'h003, 0, 0, 1, 1, 1, 0);
      send("R6", 10'h3FC, 0, 0, 0, 0, 0, 0);
      send("R7", 10'h300, 1, 0, 0, 0, 0, 0);
      // R8 flags one at a time
      send("R8", 10'h000, 1, 1, 0, 0, 0, 0);
      send("R8", 10'h000, 1, 0, 1, 0, 0, 0);
      send("R8", 10'h000, 1, 0, 0, 1, 0, 0);
      send("R8", 10'h000, 1, 0, 0, 0, 1, 0);
      // R9 mode held through a frame
      send("R9", 10'h201, 0, 0, 0, 0, 0, 0);
      send("R9", 10'h301, 1, 1, 1, 1, 0, 0);
      send("R9", 10'h3FF, 1, 1, 1, 1, 0, 0);
      send("R9", 10'h3FF, 1, 0, 0, 0, 0, 0);
      send("R9", 10'h3FF, 0, 1, 1, 1, 0, 0);
      // R10 inputs changed inside the period
      for (int i = 0; i < 6; i++)
         send("R10", 10'($urandom), 1'($urandom), 1'($urandom), 1, 1, 0, 1);
      // random mix
      begin
         logic fv = 0;
         for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 15) == 0) fv = ~fv;
            send("R2", 10'($urandom), 1'($urandom), fv, 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
         end
      end
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule